// File: doc/BRIEF.md
# Event-to-Interrupt Aggregation Controller

The block gathers single-cycle event strobes from many sources into three 32-bit pending words, giving up to 96 distinct event codes. Each strobe carries a 7-bit code: the upper two bits pick the pending word and the lower five bits pick the bit inside it. An event only ever sets its own bit. Software reads the pending words over a simple register port. It clears serviced events by writing ones to the bits it wants cleared.

Three mask banks each hold one 32-bit mask per pending word. Each bank drives one level-sensitive interrupt line: a high-priority, a mid-priority and a low-priority line. A line is high while at least one pending bit, in any of the three words, is also enabled in that line's bank. The lines are registered and recomputed every cycle from the pending and mask state. A mask write therefore raises or drops a line one cycle later, even when no event arrives.

Register addresses are four bits wide. Bits 3:2 select the bank: 0 is pending, 1 is mask A, 2 is mask B and 3 is mask C. Bits 1:0 select the word, from 0 to 2. Word index 3 does not exist.

Top module: `evagg_top`

## Requirements
- R1: After reset all pending words and all mask words read as zero, and irqHigh, irqMid and irqLow are low.
- R2: An event with evValid high and code bits 6:5 equal to 0, 1 or 2 sets, at the next clock edge, bit evCode[4:0] of the pending word with that index. It leaves every other pending bit as it was.
- R3: An event whose code bits 6:5 equal 3 changes no pending bit.
- R4: A write to a pending word (regAddr[3:2]=0) clears exactly the bits written as 1 and leaves the other bits unchanged.
- R5: When an event and a clearing write target the same pending bit in the same cycle, the bit ends up set.
- R6: A write with regAddr[3:2] equal to 1, 2 or 3 stores the full 32-bit value into the word of mask bank A, B or C selected by regAddr[1:0]. That value then reads back.
- R7: At each clock edge, irqHigh takes the OR over the three words of (pending AND bank-A mask) as it stood before that edge. irqMid does the same with bank B and irqLow with bank C.
- R8: A line stays high after a clear while any masked pending bit remains in any word. It drops on the edge after the last such bit is cleared.
- R9: A mask write alone, with no event, raises or drops a line one cycle after the write edge.
- R10: A read returns the addressed word combinationally and changes no state. Addresses with regAddr[1:0]=3 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event strobe, one cycle per event |
| evCode | input | 7 | Event code: [6:5] word, [4:0] bit |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | [3:2] bank (0 pending, 1 A, 2 B, 3 C), [1:0] word |
| regWdata | input | 32 | Write data (ones clear, for pending) |
| regRdata | output | 32 | Read data for regAddr |
| irqHigh | output | 1 | Bank-A interrupt line, highest priority |
| irqMid | output | 1 | Bank-B interrupt line |
| irqLow | output | 1 | Bank-C interrupt line, lowest priority |

## Verification
The assertions assume that evValid and regWe are never unknown after reset, and that evCode and regAddr are defined whenever their strobe is high. The clear property also assumes that no event hits the cleared word in the same cycle; the collision case is checked separately.

The stimulus drives every input to a defined value at each falling edge. It releases the strobes after one cycle. It draws codes and addresses across their full range, including the unused word index 3, so that the ignored cases still satisfy the properties.

// File: rtl/evagg_pkg.sv
package evagg_pkg;
  parameter int NUM_WORDS  = 3;
  parameter int WORD_W     = 32;
  parameter int NUM_LINES  = 3;
  parameter int BIT_IDX_W  = $clog2(WORD_W);
  parameter int WORD_IDX_W = 2;
  parameter int CODE_W     = WORD_IDX_W + BIT_IDX_W;
  parameter int BANK_W     = 2;
  parameter int ADDR_W     = BANK_W + WORD_IDX_W;

  typedef struct packed {
    logic [NUM_WORDS-1:0]                 pendClr;
    logic [NUM_LINES-1:0][NUM_WORDS-1:0]  maskWr;
    logic [NUM_WORDS-1:0]                 evWord;
    logic [BIT_IDX_W-1:0]                 evBit;
    logic [BANK_W-1:0]                    rdBank;
    logic [WORD_IDX_W-1:0]                rdWord;
    logic                                 rdValid;
  } ctrlStrobes_t;
endpackage

// File: rtl/evagg_ctrl.sv
module evagg_ctrl
  import evagg_pkg::*;
(
  input  logic              evValid,
  input  logic [CODE_W-1:0] evCode,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  localparam logic [WORD_IDX_W-1:0] LAST_WORD = WORD_IDX_W'(NUM_WORDS - 1);
  localparam logic [BANK_W-1:0]     PEND_BANK = '0;

  logic [WORD_IDX_W-1:0] wordIdx;
  logic [BANK_W-1:0]     bankIdx;
  logic [WORD_IDX_W-1:0] evWordIdx;
  logic                  wordOk;
  logic                  evWordOk;

  assign wordIdx   = regAddr[WORD_IDX_W-1:0];
  assign bankIdx   = regAddr[ADDR_W-1:WORD_IDX_W];
  assign evWordIdx = evCode[CODE_W-1:BIT_IDX_W];
  assign wordOk    = (wordIdx <= LAST_WORD);
  assign evWordOk  = (evWordIdx <= LAST_WORD);

  always_comb begin
    strobes = '0;
    if (regWe && wordOk) begin
      if (bankIdx == PEND_BANK) strobes.pendClr[wordIdx] = 1'b1;
      else                      strobes.maskWr[bankIdx - 2'd1][wordIdx] = 1'b1;
    end
    if (evValid && evWordOk) strobes.evWord[evWordIdx] = 1'b1;
    strobes.evBit   = evCode[BIT_IDX_W-1:0];
    strobes.rdBank  = bankIdx;
    strobes.rdWord  = wordIdx;
    strobes.rdValid = wordOk;
  end
endmodule

// File: rtl/evagg_datapath.sv
module evagg_datapath
  import evagg_pkg::*;
(
  input  logic                                             clk,
  input  logic                                             rstN,
  input  ctrlStrobes_t                                     strobes,
  input  logic [WORD_W-1:0]                                regWdata,
  output logic [WORD_W-1:0]                                regRdata,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]                 pendQ,
  output logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0]  maskQ,
  output logic [NUM_LINES-1:0]                             irqQ
);
  logic [NUM_LINES-1:0] lineHit;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pend
    logic [WORD_W-1:0] setBits;
    logic [WORD_W-1:0] clrBits;
    assign setBits = strobes.evWord[w] ? (WORD_W'(1) << strobes.evBit) : '0;
    assign clrBits = strobes.pendClr[w] ? regWdata : '0;
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[w] <= '0;
      else       pendQ[w] <= (pendQ[w] & ~clrBits) | setBits;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)                     maskQ[l][w] <= '0;
        else if (strobes.maskWr[l][w]) maskQ[l][w] <= regWdata;
      end
    end
    always_comb begin
      lineHit[l] = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++)
        lineHit[l] = lineHit[l] | (|(pendQ[w] & maskQ[l][w]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= '0;
    else       irqQ <= lineHit;
  end

  always_comb begin
    regRdata = '0;
    if (strobes.rdValid) begin
      if (strobes.rdBank == '0) regRdata = pendQ[strobes.rdWord];
      else                      regRdata = maskQ[strobes.rdBank - 2'd1][strobes.rdWord];
    end
  end
endmodule

// File: rtl/evagg_top.sv
module evagg_top
  import evagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [CODE_W-1:0] evCode,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              irqHigh,
  output logic              irqMid,
  output logic              irqLow
);
  ctrlStrobes_t                                    strobes;
  logic [NUM_WORDS-1:0][WORD_W-1:0]                pendQ;
  logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0] maskQ;
  logic [NUM_LINES-1:0]                            irqQ;

  evagg_ctrl i_ctrl (
    .evValid (evValid),
    .evCode  (evCode),
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  evagg_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pendQ    (pendQ),
    .maskQ    (maskQ),
    .irqQ     (irqQ)
  );

  assign irqHigh = irqQ[0];
  assign irqMid  = irqQ[1];
  assign irqLow  = irqQ[2];
endmodule

// File: rtl/evagg_checker.sv
module evagg_checker
  import evagg_pkg::*;
(
  input logic                                      clk,
  input logic                                      rstN,
  input logic                                      evValid,
  input logic [CODE_W-1:0]                         evCode,
  input logic                                      regWe,
  input logic [ADDR_W-1:0]                         regAddr,
  input logic [WORD_W-1:0]                         regWdata,
  input logic [NUM_WORDS*WORD_W-1:0]               pendV,
  input logic [NUM_LINES*NUM_WORDS*WORD_W-1:0]     maskV,
  input logic                                      irqHigh,
  input logic                                      irqMid,
  input logic                                      irqLow
);
  localparam int TOT = NUM_WORDS * WORD_W;

  logic [NUM_LINES-1:0] anyHit;
  logic [7:0]           evIdx;
  logic                 evOk;
  logic [TOT-1:0]       clrSpread;
  logic                 clrNoEv;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_hit
    assign anyHit[l] = |(pendV & maskV[l*TOT +: TOT]);
  end

  assign evOk  = (evCode[CODE_W-1:BIT_IDX_W] != 2'd3);
  assign evIdx = {1'b0, evCode[CODE_W-1:BIT_IDX_W], 5'd0} + {3'd0, evCode[BIT_IDX_W-1:0]};
  assign clrNoEv = regWe && regAddr[3:2] == 2'd0 && regAddr[1:0] != 2'd3 && !evValid;
  assign clrSpread = TOT'(regWdata) << (regAddr[1:0] * WORD_W);

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evOk) |=> pendV[$past(evIdx)]);

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |=> ((pendV & ~$past(pendV)) == '0));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rstN)
    clrNoEv |=> ((pendV & $past(clrSpread)) == '0));

  a_r7_high_line: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqHigh == $past(anyHit[0])));

  a_r7_mid_line: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqMid == $past(anyHit[1])));

  a_r7_low_line: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqLow == $past(anyHit[2])));

  a_r8_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    irqHigh |-> $past(maskV[TOT-1:0] != '0));
endmodule

bind evagg_top evagg_checker i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .evValid  (evValid),
  .evCode   (evCode),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .pendV    (pendQ),
  .maskV    (maskQ),
  .irqHigh  (irqHigh),
  .irqMid   (irqMid),
  .irqLow   (irqLow)
);

// File: tb/test_evagg_top.sv
module test_evagg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic [6:0]  evCode = '0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqHigh, irqMid, irqLow;

  int errors = 0;
  int checks = 0;

  logic [31:0] mPend [3];
  logic [31:0] mMask [3][3];

  always #(CLK_PERIOD/2) clk = ~clk;

  evagg_top i_evagg_top (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evCode(evCode),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqHigh(irqHigh), .irqMid(irqMid), .irqLow(irqLow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] modelIrq();
    logic [2:0] r = '0;
    for (int l = 0; l < 3; l++)
      for (int w = 0; w < 3; w++)
        if ((mPend[w] & mMask[l][w]) != 0) r[l] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] modelRead(logic [3:0] a);
    if (a[1:0] == 2'd3) return '0;
    if (a[3:2] == 2'd0) return mPend[a[1:0]];
    return mMask[a[3:2] - 2'd1][a[1:0]];
  endfunction

  task automatic step(string req, logic ev, logic [6:0] code,
                      logic we, logic [3:0] addr, logic [31:0] wd);
    logic [2:0] expIrq;
    @(negedge clk);
    evValid = ev; evCode = code; regWe = we; regAddr = addr; regWdata = wd;
    @(posedge clk);
    #1;
    expIrq = modelIrq();
    if (we && addr[1:0] != 2'd3) begin
      if (addr[3:2] == 2'd0) mPend[addr[1:0]] = mPend[addr[1:0]] & ~wd;
      else mMask[addr[3:2] - 2'd1][addr[1:0]] = wd;
    end
    if (ev && code[6:5] != 2'd3) mPend[code[6:5]] = mPend[code[6:5]] | (32'd1 << code[4:0]);
    evValid = 1'b0; regWe = 1'b0;
    chk(req, {29'd0, irqLow, irqMid, irqHigh}, {29'd0, expIrq});
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 7'd0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic readChk(string req, logic [3:0] a);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, regRdata, modelRead(a));
  endtask

  task automatic readAll(string req);
    for (int a = 0; a < 16; a++) readChk(req, 4'(a));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < 3; w++) begin
      mPend[w] = '0;
      for (int l = 0; l < 3; l++) mMask[l][w] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    #1 chk("R1", {29'd0, irqLow, irqMid, irqHigh}, 32'd0);
    readAll("R1");

    // R2 event word 1 bit 7
    step("R2", 1'b1, {2'd1, 5'd7}, 1'b0, 4'd0, 0);
    readChk("R2", 4'h1); readChk("R2", 4'h0); readChk("R2", 4'h2);
    // R6 mask A word1, R9 line rises from mask alone
    step("R6", 1'b0, 0, 1'b1, {2'd1, 2'd1}, 32'h0000_0080);
    readChk("R6", {2'd1, 2'd1});
    idle("R9");
    chk("R9", {31'd0, irqHigh}, 32'd1);
    // R3 invalid word index
    step("R3", 1'b1, {2'd3, 5'd4}, 1'b0, 4'd0, 0);
    readAll("R3");
    // R5 collision on word0 bit5
    step("R5", 1'b1, {2'd0, 5'd5}, 1'b1, {2'd0, 2'd0}, 32'h0000_0020);
    readChk("R5", 4'h0);
    chk("R5", regRdata & 32'h20, 32'h20);
    // R8 two sources for line A plus line B
    step("R6", 1'b0, 0, 1'b1, {2'd1, 2'd0}, 32'h0000_0020);
    step("R6", 1'b0, 0, 1'b1, {2'd2, 2'd0}, 32'h0000_0020);
    idle("R7"); idle("R7");
    chk("R7", {30'd0, irqMid, irqHigh}, 32'd3);
    step("R4", 1'b0, 0, 1'b1, {2'd0, 2'd0}, 32'h0000_0020);
    readChk("R4", 4'h0);
    idle("R8");
    chk("R8", {30'd0, irqMid, irqHigh}, 32'd1);
    step("R4", 1'b0, 0, 1'b1, {2'd0, 2'd1}, 32'hFFFF_FF7F);
    readChk("R4", 4'h1);
    step("R4", 1'b0, 0, 1'b1, {2'd0, 2'd1}, 32'h0000_0080);
    idle("R8");
    chk("R8", {31'd0, irqHigh}, 32'd0);
    // R9 mask drop on line C
    step("R6", 1'b0, 0, 1'b1, {2'd3, 2'd2}, 32'h0000_0001);
    step("R2", 1'b1, {2'd2, 5'd0}, 1'b0, 4'd0, 0);
    idle("R7");
    chk("R7", {31'd0, irqLow}, 32'd1);
    step("R9", 1'b0, 0, 1'b1, {2'd3, 2'd2}, 32'd0);
    idle("R9");
    chk("R9", {31'd0, irqLow}, 32'd0);
    // R10 repeated read, and a write to word index 3
    readChk("R10", 4'h2); readChk("R10", 4'h2);
    step("R10", 1'b0, 0, 1'b1, {2'd1, 2'd3}, 32'hFFFF_FFFF);
    step("R10", 1'b0, 0, 1'b1, {2'd0, 2'd3}, 32'hFFFF_FFFF);
    readAll("R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      wd = ($urandom % 4 == 0) ? $urandom : (32'd1 << ($urandom % 32));
      step("R7", ($urandom % 3) != 0, 7'($urandom), ($urandom % 3) == 0,
           4'($urandom), wd);
      if (i % 8 == 0) readChk("R10", 4'($urandom));
    end
    readAll("R4");
    finishRun();
  end
endmodule